// File: doc/BRIEF.md
# Command-Driven I2C Bus Master

This block is an I2C bus master that a host steers one primitive action at a time. The host writes a 4-bit code into a command register. The block then does exactly one thing on the bus: it releases the bus, drives a START, drives a STOP, reads a byte (with or without acknowledging it), or writes a byte. When the action is over, a done flag and the outcome flags appear in a status register. Every status bit that is not blocked in a mask register feeds one interrupt line.

A whole transaction is built from a chain of these commands, for example START, address write, data reads, STOP. After each command except STOP, the master holds SCL low so that the bus stays suspended until the host issues the next command. STOP completes and returns to the released idle state without any further write.

Bit timing comes from a prescaler that divides the system clock by a programmable divisor. SDA and SCL are open-drain lines, each modelled as an output enable that pulls the line low, plus an input that reads the line.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the status register reads 0, the interrupt output is low, both line enables are 0 and the divisor is 0.
- R2: While the divisor is 0 or 1, the prescaler is stopped and the master is held in reset. Both lines are released, and command writes have no effect on status or on the lines.
- R3: One bus bit lasts 8 prescaler ticks of DIV system clocks each. Consecutive SCL rising edges within a byte are therefore 8×DIV clocks apart.
- R4: Command code 1 (START) waits while another master's transaction is in progress. Such a transaction is detected as an SDA fall with SCL high and ended by an SDA rise with SCL high. The command then drives SDA low while SCL is high, sets D, and keeps SCL pulled low afterwards.
- R5: Command code 6 (write) shifts the transmit byte out MSB first, one bit per SCL pulse, and then releases SDA for a ninth pulse. NA is set when SDA is high at that ninth pulse.
- R6: Command code 4 (read) samples 8 bits MSB first into the receive register and leaves SDA released (high) during the ninth pulse.
- R7: Command code 5 (read with acknowledge) stores the byte in the same way as code 4, but pulls SDA low during the ninth pulse.
- R8: Command code 2 (STOP) raises SDA while SCL is high, sets D, and then releases both lines without any further command.
- R9: Codes 0, 3 and every other code not listed above release both lines, return the master to idle and set no status bit.
- R10: When a write bit that the master leaves released (a 1) is read back low while SCL is high, the master sets both LA and D and releases both lines on the next cycle.
- R11: A command written while an action is still running is dropped and sets ERR. The running action carries on unchanged.
- R12: Status bits are D at bit 0, NA at bit 1, LA at bit 2 and ERR at bit 3. An accepted command write clears all four. The interrupt is the OR of the status bits whose mask bit is 0; a mask bit of 1 blocks that status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_code | input | 4 | Command code written with cmd_we |
| div_we | input | 1 | Write strobe for the prescaler divisor |
| div_val | input | DIV_W | New divisor value |
| tx_we | input | 1 | Write strobe for the transmit byte |
| tx_byte | input | 8 | Byte sent by the write command |
| mask_we | input | 1 | Write strobe for the status mask |
| mask_val | input | 4 | New mask value (1 blocks the status bit) |
| rx_data | output | 8 | Byte captured by the last read command |
| status | output | 4 | {ERR, LA, NA, D} |
| irq | output | 1 | OR of unmasked status bits |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
On every cycle, the assertions check a set of local rules. The prescaler never emits two ticks in a row. The bit phase never moves between ticks. Holding the master in reset releases both lines. A detected arbitration loss or a finished STOP leaves both lines released one cycle later. A rejected command always shows up in ERR, and a fully masked status never raises the interrupt. Only the bench scenarios, run against a modelled slave and a second master, can show bus-level results: the order and value of the shifted bits, the acknowledge level at the ninth pulse, the spacing of SCL edges, the START that waits for a busy bus, and the status value at the moment D rises.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   // command codes written by the host
   localparam logic [3:0] CMD_NOP   = 4'd0;
   localparam logic [3:0] CMD_START = 4'd1;
   localparam logic [3:0] CMD_STOP  = 4'd2;
   localparam logic [3:0] CMD_RD    = 4'd4;
   localparam logic [3:0] CMD_RDACK = 4'd5;
   localparam logic [3:0] CMD_WR    = 4'd6;

   // status bit positions
   localparam int SB_DONE = 0;
   localparam int SB_NACK = 1;
   localparam int SB_LOST = 2;
   localparam int SB_ERR  = 3;
   localparam int SB_NUM  = 4;

   localparam int BIT_PHASES = 8;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_RUN,
      ENG_SUSP
   } eng_state_e;

endpackage

// File: rtl/i2cm_prescale.sv
module i2cm_prescale #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             stop,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign stop = (div < DIV_W'(2));
   assign tick = !stop && (cnt_q == div - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (stop || tick) cnt_q <= '0;
      else                   cnt_q <= cnt_q + DIV_W'(1);
   end

   // R3
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n || stop)
      tick |=> !tick);

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
   import i2cm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold,
   input  logic       tick,
   input  logic       cmd_we,
   input  logic [3:0] cmd_code,
   input  logic [7:0] tx_byte,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic       acc_p,
   output logic       rej_p,
   output logic       done_p,
   output logic       na_p,
   output logic       la_p,
   output logic       rx_p,
   output logic [7:0] rx_byte
);

   localparam int PH_W = $clog2(BIT_PHASES);
   localparam logic [PH_W-1:0] PH_SCL_HI  = PH_W'(2);
   localparam logic [PH_W-1:0] PH_SCL_CHK = PH_W'(3);
   localparam logic [PH_W-1:0] PH_SAMPLE  = PH_W'(4);
   localparam logic [PH_W-1:0] PH_LATE    = PH_W'(6);
   localparam logic [PH_W-1:0] PH_LAST    = PH_W'(BIT_PHASES - 1);
   localparam logic [3:0]      ACK_BIT    = 4'd8;

   logic scl_s, sda_s;

   // input synchronizer variant chosen by parameter
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign scl_s = scl_i;
         assign sda_s = sda_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] scl_ch, sda_ch;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ch <= '1;
               sda_ch <= '1;
            end else begin
               scl_ch <= SYNC_STAGES'({scl_ch, scl_i});
               sda_ch <= SYNC_STAGES'({sda_ch, sda_i});
            end
         end
         assign scl_s = scl_ch[SYNC_STAGES-1];
         assign sda_s = sda_ch[SYNC_STAGES-1];
      end
   endgenerate

   eng_state_e      st_q;
   logic [3:0]      op_q;
   logic [PH_W-1:0] ph_q;
   logic [3:0]      bit_q;
   logic [7:0]      sh_q;
   logic            samp_q, own_q, busy_q, scl_d, sda_d;
   logic            adv, fin, la_hit, run_code;

   assign run_code = (cmd_code == CMD_START) || (cmd_code == CMD_STOP) ||
                     (cmd_code == CMD_RD) || (cmd_code == CMD_RDACK) ||
                     (cmd_code == CMD_WR);
   assign acc_p  = cmd_we && !hold && (st_q != ENG_RUN);
   assign rej_p  = cmd_we && !hold && (st_q == ENG_RUN);

   assign adv    = (st_q == ENG_RUN) && tick &&
                   !((ph_q == PH_SCL_CHK) && !scl_s) &&
                   !((op_q == CMD_START) && (ph_q == '0) && !own_q && busy_q);
   assign la_hit = adv && (ph_q == PH_SAMPLE) && (op_q == CMD_WR) &&
                   (bit_q < ACK_BIT) && sh_q[7] && !sda_s;
   assign fin    = adv && (ph_q == PH_LAST) &&
                   ((op_q == CMD_START) || (op_q == CMD_STOP) || (bit_q == ACK_BIT));
   assign done_p = fin || la_hit;
   assign la_p   = la_hit;
   assign na_p   = adv && (ph_q == PH_SAMPLE) && (op_q == CMD_WR) &&
                   (bit_q == ACK_BIT) && sda_s;
   assign rx_p   = fin && ((op_q == CMD_RD) || (op_q == CMD_RDACK));
   assign rx_byte = sh_q;

   always_comb begin
      scl_oe = 1'b0;
      sda_oe = 1'b0;
      if (st_q == ENG_SUSP) begin
         scl_oe = 1'b1;
      end else if (st_q == ENG_RUN) begin
         if (op_q == CMD_START) begin
            scl_oe = (own_q && (ph_q < PH_SCL_HI)) || (ph_q >= PH_LATE);
            sda_oe = (ph_q >= PH_SAMPLE);
         end else if (op_q == CMD_STOP) begin
            scl_oe = (ph_q < PH_SCL_HI);
            sda_oe = (ph_q < PH_LATE);
         end else begin
            scl_oe = (ph_q < PH_SCL_HI) || (ph_q >= PH_LATE);
            if (bit_q < ACK_BIT) sda_oe = (op_q == CMD_WR) && !sh_q[7];
            else                 sda_oe = (op_q == CMD_RDACK);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ENG_IDLE; op_q <= CMD_NOP; ph_q <= '0; bit_q <= '0;
         sh_q <= '0; samp_q <= 1'b1; own_q <= 1'b0; busy_q <= 1'b0;
         scl_d <= 1'b1; sda_d <= 1'b1;
      end else if (hold) begin
         st_q <= ENG_IDLE; op_q <= CMD_NOP; ph_q <= '0; bit_q <= '0;
         sh_q <= '0; samp_q <= 1'b1; own_q <= 1'b0; busy_q <= 1'b0;
         scl_d <= 1'b1; sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
         if (scl_s && scl_d && sda_d && !sda_s)      busy_q <= 1'b1;
         else if (scl_s && scl_d && !sda_d && sda_s) busy_q <= 1'b0;

         if (acc_p) begin
            ph_q  <= '0;
            bit_q <= '0;
            own_q <= (st_q == ENG_SUSP);
            op_q  <= cmd_code;
            if (run_code) begin
               st_q <= ENG_RUN;
               if (cmd_code == CMD_WR) sh_q <= tx_byte;
            end else begin
               st_q <= ENG_IDLE;
            end
         end else if (adv) begin
            ph_q <= ph_q + PH_W'(1);
            if (ph_q == PH_SAMPLE) samp_q <= sda_s;
            if (la_hit) begin
               st_q <= ENG_IDLE;
            end else if (ph_q == PH_LAST) begin
               if (fin) begin
                  st_q <= (op_q == CMD_STOP) ? ENG_IDLE : ENG_SUSP;
               end else begin
                  bit_q <= bit_q + 4'd1;
                  sh_q  <= {sh_q[6:0], samp_q};
               end
            end
         end
      end
   end

   // R2
   hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (!scl_oe && !sda_oe));

   // R10
   lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n || hold)
      la_hit |=> (!scl_oe && !sda_oe));

   // R3
   phase_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ENG_RUN) && !tick && !hold && !cmd_we) |=> $stable(ph_q));

   // R8
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || hold)
      (fin && (op_q == CMD_STOP)) |=> (st_q == ENG_IDLE && !scl_oe && !sda_oe));

endmodule

// File: rtl/i2cm_status.sv
module i2cm_status #(
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [NB-1:0] set,
   input  logic          mask_we,
   input  logic [NB-1:0] mask_val,
   output logic [NB-1:0] st_q,
   output logic          irq
);

   logic [NB-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= '0;
         mask_q <= '0;
      end else begin
         st_q <= (clr ? '0 : st_q) | set;
         if (mask_we) mask_q <= mask_val;
      end
   end

   assign irq = |(st_q & ~mask_q);

   // R12
   mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '1) |-> !irq);

   // R11
   err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[NB-1] |=> st_q[NB-1]);

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
   import i2cm_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [3:0]       cmd_code,
   input  logic             div_we,
   input  logic [DIV_W-1:0] div_val,
   input  logic             tx_we,
   input  logic [7:0]       tx_byte,
   input  logic             mask_we,
   input  logic [3:0]       mask_val,
   output logic [7:0]       rx_data,
   output logic [3:0]       status,
   output logic             irq,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             scl_oe,
   output logic             sda_oe
);

   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("DIV_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [7:0]       tx_q;
   logic [7:0]       rx_q;
   logic [7:0]       rx_byte;
   logic             stop, tick;
   logic             acc_p, rej_p, done_p, na_p, la_p, rx_p;
   logic [SB_NUM-1:0] set_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         tx_q  <= '0;
         rx_q  <= '0;
      end else begin
         if (div_we) div_q <= div_val;
         if (tx_we)  tx_q  <= tx_byte;
         if (rx_p)   rx_q  <= rx_byte;
      end
   end

   i2cm_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .div(div_q), .stop(stop), .tick(tick)
   );

   i2cm_engine #(.SYNC_STAGES(SYNC_STAGES)) u_eng (
      .clk(clk), .rst_n(rst_n), .hold(stop), .tick(tick),
      .cmd_we(cmd_we), .cmd_code(cmd_code), .tx_byte(tx_q),
      .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .acc_p(acc_p), .rej_p(rej_p), .done_p(done_p), .na_p(na_p),
      .la_p(la_p), .rx_p(rx_p), .rx_byte(rx_byte)
   );

   always_comb begin
      set_v          = '0;
      set_v[SB_DONE] = done_p;
      set_v[SB_NACK] = na_p;
      set_v[SB_LOST] = la_p;
      set_v[SB_ERR]  = rej_p;
   end

   i2cm_status #(.NB(SB_NUM)) u_stat (
      .clk(clk), .rst_n(rst_n), .clr(acc_p), .set(set_v),
      .mask_we(mask_we), .mask_val(mask_val), .st_q(status), .irq(irq)
   );

   assign rx_data = rx_q;

endmodule

// File: tb/i2c_cmd_master_test.sv
module i2c_cmd_master_test;

   localparam int DW   = 8;
   localparam int DIVT = 3;

   typedef struct {
      logic [3:0] st;
      bit         cd;
      logic [7:0] d;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          cmd_we = 0, div_we = 0, tx_we = 0, mask_we = 0;
   logic [3:0]    cmd_code = 0, mask_val = 0;
   logic [DW-1:0] div_val = 0;
   logic [7:0]    tx_byte = 0;
   logic [7:0]    rx_data;
   logic [3:0]    status;
   logic          irq, scl_oe, sda_oe;
   logic          scl_line, sda_line, slv_low;
   logic          oth_low = 0;

   // slave model controls
   bit         slv_act = 0, slv_rd = 0, slv_ack = 0;
   logic [7:0] slv_byte = 0;
   int         nfall = 0, fbase = 0, nrise = 0, rbase = 0, nstop = 0, nstart = 0;
   int         cyc = 0;
   int         rtime [0:1023];
   logic       rbit  [0:1023];
   int         scnt;

   int   nchk = 0, nerr = 0;
   bit   finished = 0;
   exp_t sbq[$];

   assign scnt     = nfall - fbase;
   assign slv_low  = slv_act && ((slv_rd && scnt < 8 && !slv_byte[3'(7 - scnt)]) ||
                                 (!slv_rd && scnt == 8 && slv_ack));
   assign scl_line = !scl_oe;
   assign sda_line = !(sda_oe || slv_low || oth_low);

   i2c_cmd_master #(.DIV_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
      .div_we(div_we), .div_val(div_val), .tx_we(tx_we), .tx_byte(tx_byte),
      .mask_we(mask_we), .mask_val(mask_val), .rx_data(rx_data),
      .status(status), .irq(irq), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge scl_line) nfall <= nfall + 1;
   always @(posedge scl_line) begin
      rtime[nrise % 1024] = cyc;
      rbit[nrise % 1024]  = sda_line;
      nrise = nrise + 1;
   end
   always @(posedge sda_line) if (scl_line === 1'b1) nstop = nstop + 1;
   always @(negedge sda_line) if (scl_line === 1'b1) nstart = nstart + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
      end
   endtask

   // scoreboard monitor: compares at each rise of D
   initial begin
      logic pd;
      exp_t e;
      pd = 1'b0;
      forever begin
         @(negedge clk);
         if (status[0] && !pd) begin
            if (sbq.size() == 0) begin
               chk("R12", 32'(status), 32'hFFFF, "unexpected D rise");
            end else begin
               e = sbq.pop_front();
               chk(e.tag, 32'(status), 32'(e.st), "status at D");
               if (e.cd) chk(e.tag, 32'(rx_data), 32'(e.d), "rx data");
            end
         end
         pd = status[0];
      end
   end

   task automatic wr_cmd(input logic [3:0] c);
      @(negedge clk); cmd_code = c; cmd_we = 1;
      @(negedge clk); cmd_we = 0;
   endtask

   task automatic set_div(input logic [DW-1:0] v);
      @(negedge clk); div_val = v; div_we = 1;
      @(negedge clk); div_we = 0;
   endtask

   task automatic set_tx(input logic [7:0] v);
      @(negedge clk); tx_byte = v; tx_we = 1;
      @(negedge clk); tx_we = 0;
   endtask

   task automatic set_mask(input logic [3:0] v);
      @(negedge clk); mask_val = v; mask_we = 1;
      @(negedge clk); mask_we = 0;
   endtask

   task automatic wait_empty(input string tag);
      int n;
      n = 0;
      while (sbq.size() != 0 && n < 20000) begin
         @(negedge clk); n++;
      end
      chk(tag, 32'(sbq.size()), 0, "command completion");
      sbq.delete();
      @(negedge clk);
   endtask

   // driver: queue the expectation, then issue
   task automatic post(input logic [3:0] c, input logic [3:0] st, input bit cd,
                       input logic [7:0] d, input string tag);
      exp_t e;
      e.st = st; e.cd = cd; e.d = d; e.tag = tag;
      sbq.push_back(e);
      fbase = nfall;
      rbase = nrise;
      wr_cmd(c);
   endtask

   task automatic slave(input bit act, input bit rd, input bit ack, input logic [7:0] b);
      slv_act = act; slv_rd = rd; slv_ack = ack; slv_byte = b;
   endtask

   function automatic logic [7:0] rx_bits(input int base);
      logic [7:0] v;
      for (int i = 0; i < 8; i++) v[7 - i] = rbit[(base + i) % 1024];
      return v;
   endfunction

   initial begin
      int s0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", 32'(status), 0, "status after reset");
      chk("R1", 32'(irq), 0, "irq after reset");
      chk("R1", 32'({scl_oe, sda_oe}), 0, "lines after reset");

      // R2 divisor 0: command ignored
      wr_cmd(4'd1);
      repeat (50) @(negedge clk);
      chk("R2", 32'(status), 0, "status with DIV=0");
      chk("R2", 32'({scl_oe, sda_oe}), 0, "lines with DIV=0");

      set_div(DW'(DIVT));

      // R4 START on a free bus
      s0 = nstart;
      post(4'd1, 4'b0001, 0, 8'h00, "R4");
      wait_empty("R4");
      chk("R4", 32'(nstart - s0), 1, "start edges");
      chk("R4", 32'(scl_oe), 1, "SCL held low after START");

      // R5 write with ack, and R3 bit spacing
      set_tx(8'hA5);
      slave(1, 0, 1, 8'h00);
      post(4'd6, 4'b0001, 0, 8'h00, "R5");
      wait_empty("R5");
      chk("R5", 32'(rx_bits(rbase)), 32'hA5, "bits on bus MSB first");
      chk("R3", 32'(rtime[(rbase + 1) % 1024] - rtime[rbase % 1024]), 32'(8 * DIVT),
          "SCL rise spacing");

      // R5 write without ack -> NA
      set_tx(8'h3C);
      slave(1, 0, 0, 8'h00);
      post(4'd6, 4'b0011, 0, 8'h00, "R5");
      wait_empty("R5");

      // R6 read, ninth bit released
      slave(1, 1, 0, 8'hC3);
      post(4'd4, 4'b0001, 1, 8'hC3, "R6");
      wait_empty("R6");
      chk("R6", 32'(rbit[(rbase + 8) % 1024]), 1, "ninth bit level");

      // R7 read with acknowledge
      slave(1, 1, 0, 8'h5A);
      post(4'd5, 4'b0001, 1, 8'h5A, "R7");
      wait_empty("R7");
      chk("R7", 32'(rbit[(rbase + 8) % 1024]), 0, "ninth bit level");

      // R12 interrupt and mask
      chk("R12", 32'(irq), 1, "irq with D unmasked");
      set_mask(4'b0001);
      chk("R12", 32'(irq), 0, "irq with D masked");

      // R11 command written mid-action is dropped, ERR set
      set_tx(8'h81);
      slave(1, 0, 1, 8'h00);
      post(4'd6, 4'b1001, 1, 8'h5A, "R11");
      repeat (10) @(negedge clk);
      wr_cmd(4'd4);
      wait_empty("R11");
      chk("R11", 32'(rx_bits(rbase)), 32'h81, "write kept running");
      chk("R12", 32'(irq), 1, "irq from ERR with D masked");
      set_mask(4'hF);
      chk("R12", 32'(irq), 0, "irq fully masked");
      set_mask(4'h0);

      // R8 STOP
      slave(0, 0, 0, 8'h00);
      s0 = nstop;
      post(4'd2, 4'b0001, 0, 8'h00, "R8");
      wait_empty("R8");
      repeat (3) @(negedge clk);
      chk("R8", 32'(nstop - s0), 1, "stop edges");
      chk("R8", 32'({scl_oe, sda_oe}), 0, "lines after STOP");

      // R9 NOP clears status from idle
      wr_cmd(4'd0);
      @(negedge clk);
      chk("R9", 32'(status), 0, "status after NOP");
      chk("R9", 32'({scl_oe, sda_oe}), 0, "lines after NOP");

      // R4 START waits for another master
      @(negedge clk); oth_low = 1;
      repeat (5) @(negedge clk);
      post(4'd1, 4'b0001, 0, 8'h00, "R4");
      repeat (300) @(negedge clk);
      chk("R4", 32'({status[0], sda_oe}), 0, "START held while bus busy");
      oth_low = 0;
      wait_empty("R4");

      // R10 lost arbitration on a released bit
      set_tx(8'hFF);
      @(negedge clk); oth_low = 1;
      post(4'd6, 4'b0101, 0, 8'h00, "R10");
      wait_empty("R10");
      chk("R10", 32'({scl_oe, sda_oe}), 0, "lines after lost arbitration");
      oth_low = 0;
      repeat (10) @(negedge clk);

      // R9 reserved code 3 clears status
      wr_cmd(4'd3);
      @(negedge clk);
      chk("R9", 32'(status), 0, "status after reserved code");

      // R2 divisor dropped to 0 mid-transaction
      post(4'd1, 4'b0001, 0, 8'h00, "R2");
      wait_empty("R2");
      chk("R2", 32'(scl_oe), 1, "suspended before hold");
      set_div(DW'(0));
      repeat (3) @(negedge clk);
      chk("R2", 32'({scl_oe, sda_oe}), 0, "lines released in hold");
      wr_cmd(4'd0);
      repeat (20) @(negedge clk);
      chk("R2", 32'(status), 32'b0001, "command ignored in hold");

      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

endmodule